// File: doc/BRIEF.md
# Two-Way Set-Associative Lookup and Replacement Unit

This unit holds the tags, valid bits and replacement state of a two-way set-associative cache. Data is stored elsewhere. Each request names a block address. The set is the block address modulo the number of sets, and the rest of the address is the tag. Both ways of that set are compared at once, with one comparator per way. One cycle later the unit reports whether the block is present. On a hit it returns the way that matched. On a miss it returns the way that should receive the block.

A separate fill port writes a block's tag into a named way and marks that way valid. Moving data to and from memory is left to the surrounding cache controller. That controller passes the reported victim way back on the fill port once the block has arrived.

Each set carries a two-state replacement machine.
- States:
  - `EVICT_W0`: way 0 is the least recently used.
  - `EVICT_W1`: way 1 is the least recently used. This is the reset state.
- Transitions:
  - *use-0*: a hit on way 0 or a fill of way 0 moves the set to `EVICT_W1`.
  - *use-1*: a hit on way 1 or a fill of way 1 moves the set to `EVICT_W0`.
  - *hold*: any other cycle leaves the state unchanged.

When a miss is reported, an invalid way is preferred over the replacement state. If both ways are invalid, way 0 is chosen.

Top module: `way2_lookup`

## Requirements
- R1: The set index is the low log2(SETS) bits of the block address (block modulo SETS) and the tag is the remaining upper bits; requests and fills to one set never change the contents or replacement state of another set.
- R2: A request whose tag matches a valid way of its set gives rsp_hit=1 and rsp_way equal to the matching way (0 or 1), with both ways compared in the same cycle.
- R3: On a miss where at least one way of the set is invalid, rsp_way names an invalid way; when both ways are invalid it is way 0, even though the reset replacement state points at way 1.
- R4: On a miss where both ways are valid, rsp_way is the least recently used way of the set.
- R5: A hit or a fill of way w makes way 1-w the least recently used of its set; a miss lookup alone leaves the replacement state unchanged.
- R6: Reset clears every valid bit, puts every set in state EVICT_W1 and holds rsp_valid, rsp_hit and rsp_way at 0.
- R7: rsp_valid is 1 in exactly the cycle after a cycle with req_valid=1 and is 0 otherwise; rsp_hit and rsp_way are 0 when rsp_valid is 0.
- R8: A fill writes the tag of fill_blk into way fill_way of its set and marks it valid; a request in the same cycle as the fill still sees the old contents, and a request in the following cycle sees the new ones.
- R9: When a hit and a fill touch the same set in one cycle, the replacement state follows the hit: it marks the way other than the hit way as least recently used.
- R10: With two sets, the block sequence 0, 8, 0, 6, 8 (each miss filled into the reported way) gives miss, miss, hit, miss, miss; block 6 evicts block 8 from way 1 and then block 8 evicts block 0 from way 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_blk | input | BLK_W | Block address to look up |
| fill_valid | input | 1 | Write a tag into the cache this cycle |
| fill_blk | input | BLK_W | Block address whose tag is written |
| fill_way | input | 1 | Way that receives the fill |
| rsp_valid | output | 1 | Lookup result is present |
| rsp_hit | output | 1 | 1 when the block was found |
| rsp_way | output | 1 | Hit way on a hit, victim way on a miss |

## Verification
A lookup and a fill can land in the same cycle and the same set. The bench provokes this in two ways. First, it looks up the same block that is being filled; the response must be a miss, and the next lookup of that block must hit. Second, it looks up a block that hits way 1 while a different block is filled into way 0. For this second case the replacement state is not visible directly. It is judged through the victim that a later miss in that set reports: way 0 if the hit's update won, way 1 if the fill's update won.

// File: rtl/way2_pkg.sv
package way2_pkg;

    // Replacement state of one set: which way is the least recently used.
    typedef enum logic {
        EVICT_W0 = 1'b0,
        EVICT_W1 = 1'b1
    } repl_state_e;

endpackage

// File: rtl/way2_tag_bank.sv
module way2_tag_bank #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             lk_valid,
    output logic             lk_match
);

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    // One comparator for this way.
    always_comb begin
        lk_valid = vld_q[lk_idx];
        lk_match = lk_valid && (tag_q[lk_idx] == lk_tag);
    end

    // R8
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);

    // R8
    fill_sets_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/way2_repl_set.sv
module way2_repl_set
    import way2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    input  logic touch_way,
    output logic evict_way
);

    repl_state_e st_q;
    repl_state_e st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EVICT_W1;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions: use-0, use-1, hold
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            EVICT_W0: if (touch && !touch_way) st_nxt = EVICT_W1;
            EVICT_W1: if (touch && touch_way)  st_nxt = EVICT_W0;
        endcase
    end

    // Output
    always_comb begin
        evict_way = (st_q == EVICT_W1);
    end

    // R5
    lru_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch |=> $stable(st_q));

    // R5
    lru_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (evict_way != $past(touch_way)));

endmodule

// File: rtl/way2_victim.sv
module way2_victim (
    input  logic vld0,
    input  logic vld1,
    input  logic lru_way,
    output logic victim
);

    // Invalid way first, way 0 when both are empty, otherwise LRU.
    always_comb begin
        victim = 1'b0;
        unique case ({vld1, vld0})
            2'b00: victim = 1'b0;
            2'b01: victim = 1'b1;
            2'b10: victim = 1'b0;
            2'b11: victim = lru_way;
        endcase
    end

endmodule

// File: rtl/way2_lookup.sv
module way2_lookup #(
    parameter int BLK_W = 12,
    parameter int SETS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             fill_valid,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic             fill_way,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_way
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = BLK_W - IDX_W;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;

    // R1: set = block modulo SETS (power of two), tag = remaining bits
    always_comb begin
        req_idx  = req_blk[IDX_W-1:0];
        req_tag  = req_blk[BLK_W-1:IDX_W];
        fill_idx = fill_blk[IDX_W-1:0];
        fill_tag = fill_blk[BLK_W-1:IDX_W];
    end

    logic [1:0] way_vld;
    logic [1:0] way_hit;

    for (genvar w = 0; w < 2; w++) begin : g_way
        way2_tag_bank #(
            .SETS  (SETS),
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (req_idx),
            .lk_tag   (req_tag),
            .wr_en    (fill_valid && (fill_way == 1'(w))),
            .wr_idx   (fill_idx),
            .wr_tag   (fill_tag),
            .lk_valid (way_vld[w]),
            .lk_match (way_hit[w])
        );
    end

    logic hit_any;
    logic hit_way;

    always_comb begin
        hit_any = |way_hit;
        hit_way = way_hit[1];
    end

    logic [SETS-1:0] set_evict;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic hit_here;
        logic fill_here;

        // R9: a hit in this set wins over a fill in the same cycle
        always_comb begin
            hit_here  = req_valid && hit_any && (req_idx == IDX_W'(s));
            fill_here = fill_valid && (fill_idx == IDX_W'(s));
        end

        way2_repl_set u_repl (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch     (hit_here || fill_here),
            .touch_way (hit_here ? hit_way : fill_way),
            .evict_way (set_evict[s])
        );
    end

    logic victim;

    way2_victim u_victim (
        .vld0    (way_vld[0]),
        .vld1    (way_vld[1]),
        .lru_way (set_evict[req_idx]),
        .victim  (victim)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && hit_any;
            rsp_way   <= req_valid && (hit_any ? hit_way : victim);
        end
    end

    // R7
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_way));

    // R2
    hit_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_any) |=> (rsp_hit && (rsp_way == $past(hit_way))));

    // R3
    invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit_any && ($countones(way_vld) == 1)) |=> (rsp_way == $past(way_vld[0])));

endmodule

// File: tb/way2_lookup_test.sv
module way2_lookup_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BLK_W = 6;
    localparam int SETS  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic             fill_valid = 1'b0;
    logic [BLK_W-1:0] fill_blk = '0;
    logic             fill_way = 1'b0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic             rsp_way;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [1:0] exp_q [$];
    string      lbl_q [$];

    always #10 clk = ~clk;

    way2_lookup #(.BLK_W(BLK_W), .SETS(SETS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .fill_valid (fill_valid),
        .fill_blk   (fill_blk),
        .fill_way   (fill_way),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_way    (rsp_way)
    );

    // Driver: called at a falling edge; expectations are pushed for the monitor.
    task automatic cycle(input bit do_req, input int blk, input bit e_hit, input bit e_way,
                         input bit do_fill, input int fblk, input bit fway, input string lbl);
        req_valid  = do_req;
        req_blk    = BLK_W'(blk);
        fill_valid = do_fill;
        fill_blk   = BLK_W'(fblk);
        fill_way   = fway;
        if (do_req) begin
            exp_q.push_back({e_hit, e_way});
            lbl_q.push_back(lbl);
        end
        @(negedge clk);
        req_valid  = 1'b0;
        fill_valid = 1'b0;
    endtask

    task automatic look(input int blk, input bit e_hit, input bit e_way, input string lbl);
        cycle(1'b1, blk, e_hit, e_way, 1'b0, 0, 1'b0, lbl);
    endtask

    task automatic fill(input int blk, input bit way);
        cycle(1'b0, 0, 1'b0, 1'b0, 1'b1, blk, way, "");
    endtask

    task automatic direct(input bit cond, input string lbl, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", lbl, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each rising edge.
    initial begin
        logic [1:0] e;
        string l;
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n || finished) continue;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                checks++;
                if (rsp_valid !== 1'b1 || rsp_hit !== e[1] || rsp_way !== e[0]) begin
                    errors++;
                    $display("FAIL %s: actual valid=%0b hit=%0b way=%0b expected valid=1 hit=%0b way=%0b",
                             l, rsp_valid, rsp_hit, rsp_way, e[1], e[0]);
                end
            end else begin
                checks++;
                if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_way !== 1'b0) begin
                    errors++;
                    $display("FAIL R7 idle: actual valid=%0b hit=%0b way=%0b expected 0 0 0",
                             rsp_valid, rsp_hit, rsp_way);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: outputs low during reset
        direct(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R6 in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        direct(rsp_valid == 1'b0, "R6 after reset", rsp_valid, 0);

        // R10: 0, 8, 0, 6, 8 in a two-set cache (set = blk mod 2)
        look(0, 0, 0, "R10 blk0 miss, R3 both invalid -> way0");
        fill(0, 0);
        look(8, 0, 1, "R10 blk8 miss, R3 invalid way1");
        fill(8, 1);
        look(0, 1, 0, "R10 blk0 hit way0, R2");
        look(6, 0, 1, "R10 blk6 evicts blk8 in way1, R4");
        fill(6, 1);
        look(8, 0, 0, "R10 blk8 evicts blk0 in way0, R4");
        fill(8, 0);

        // R1: set 1 is independent of set 0
        look(1, 0, 0, "R1 set1 empty, R3 way0");
        fill(1, 0);
        look(3, 0, 1, "R1 set1 invalid way1");
        fill(3, 1);
        look(8, 1, 0, "R1 set0 blk8 still in way0");
        look(6, 1, 1, "R1 R2 set0 blk6 in way1");

        // R5: a miss alone does not move the LRU state (set0 LRU now way0)
        look(10, 0, 0, "R5 miss victim way0");
        look(10, 0, 0, "R5 repeated miss keeps victim way0");
        look(8, 1, 0, "R5 hit way0");
        look(10, 0, 1, "R4 R5 LRU moved to way1");

        // R8: lookup in the fill cycle sees old contents (set1 LRU is way0)
        cycle(1'b1, 5, 1'b0, 1'b0, 1'b1, 5, 1'b0, "R8 same-cycle fill not visible");
        look(5, 1, 0, "R8 fill visible next cycle");

        // R9: hit on way1 and fill of way0 in set1 together
        cycle(1'b1, 3, 1'b1, 1'b1, 1'b1, 7, 1'b0, "R9 hit way1 during fill");
        look(9, 0, 0, "R9 hit update wins, victim way0");
        look(7, 1, 0, "R8 filled blk7 in way0");

        // R6: reset clears the valid bits
        rst_n = 1'b0;
        @(negedge clk);
        direct(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_way == 1'b0, "R6 mid-run reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        look(8, 0, 0, "R6 R3 valid cleared, both invalid -> way0");
        fill(8, 1);
        look(12, 0, 0, "R3 invalid way0 chosen");
        fill(12, 0);
        look(8, 1, 1, "R2 blk8 hit way1");
        look(12, 1, 0, "R2 blk12 hit way0");
        look(20, 0, 1, "R4 both valid, LRU way1");

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule